// File: doc/BRIEF.md
# Ripple-Tracking Loop Integrator

This block is a synthesizable digital model of the charge integrator that sits behind a clock-recovery phase detector. It runs on a fast oversampling clock. Two or three detector pulse lines enter through two-flop synchronizers. On every fast cycle the accumulator moves by a weighted step for each line that is high. The "early" line raises it, the "middle" line lowers it, and in three-line mode the "late" line raises it again. Rises and falls use the same slope, so a balanced pulse train leaves no net change. The accumulator saturates at both signed limits and never wraps.

Alongside the net value, the block measures the ripple that each detector burst leaves. A baseline is held while the pulse lines are quiet. During a burst, a peak register records the largest distance of the accumulator from that baseline, and an area register sums the signed distance on every cycle. A two-line detector in lock gives a triangle-shaped excursion with a positive area. A three-line detector whose middle line has double weight gives a symmetric excursion with zero area. Both results can be read from the ports. Once all lines have been low for a programmable number of cycles, the burst is over: the baseline reloads and peak and area clear.

Top module: `ripple_integrator`

## Requirements
- R1: While reset is asserted, the accumulator, peak and area outputs are all zero.
- R2: A pulse-line change applied before rising edge k first alters the accumulator on edge k+2, the third rising edge it meets, because of the two synchronizer stages.
- R3: Each cycle the synchronized early line (pulse_in bit 0) is high, the accumulator grows by STEP.
- R4: Each cycle the synchronized middle line (pulse_in bit 1) is high, the accumulator falls by STEP when tri_mode is 0 and by 2*STEP when tri_mode is 1.
- R5: The synchronized late line (pulse_in bit 2) adds STEP per cycle when tri_mode is 1, and has no effect on accumulator, peak or area when tri_mode is 0.
- R6: The accumulator is signed two's complement of ACC_W bits and saturates at 2^(ACC_W-1)-1 and at -2^(ACC_W-1) instead of wrapping.
- R7: When the synchronized lines have all been low for at least quiet_len consecutive cycles, the next edge loads the baseline from the accumulator and clears peak and area. Until then, both keep their values.
- R8: Outside the quiet state, peak holds the largest absolute difference between the accumulator and the baseline seen since the last clear.
- R9: Outside the quiet state, area adds the signed accumulator-minus-baseline difference on every cycle, saturating at its signed limits. A matched early/middle burst in two-line mode leaves a positive area. A matched early/middle/late burst in three-line mode leaves an area of exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tri_mode | input | 1 | 0: two-line weighting; 1: three-line weighting with doubled middle line |
| quiet_len | input | QUIET_W | Low cycles needed before a burst is closed |
| pulse_in | input | N_LINES | Asynchronous detector pulse lines (bit 0 early, bit 1 middle, bit 2 late) |
| acc | output | ACC_W | Signed saturating accumulator |
| peak | output | ACC_W | Largest absolute excursion from baseline in the current burst |
| area | output | AREA_W | Signed running sum of excursion in the current burst |

## Verification
Several properties are checked on every cycle. A synchronized line rises only two edges after its raw input. The accumulator stays put when no line is active and never moves by more than two steps. It holds at its upper limit, and a lone late line is ignored in two-line mode. Peak never shrinks during a burst and always covers the current excursion. Area stands still when the excursion is zero, and the quiet state clears both results. Only the bench scenarios can show the exact synchronizer latency, the weighted step sizes, the precise peak and area of two-line and three-line bursts, the length of the quiet window, and saturation at both limits.

// File: rtl/ripint_pkg.sv
package ripint_pkg;

   // Step weights of the detector lines, in units of STEP
   localparam int W_EARLY      = 1;
   localparam int W_MID_PAIR   = 1;
   localparam int W_MID_TRIPLE = 2;
   localparam int W_LATE       = 1;

   typedef enum logic {
      MODE_PAIR   = 1'b0,
      MODE_TRIPLE = 1'b1
   } weight_mode_e;

endpackage

// File: rtl/ripint_sync.sv
module ripint_sync #(
   parameter int N_LINES = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] raw,
   output logic [N_LINES-1:0] lines
);

   generate
      if (N_LINES < 2 || N_LINES > 3) begin : g_bad_lines
         $error("ripint_sync: N_LINES must be 2 or 3");
      end

      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         logic meta;
         logic held;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta <= 1'b0;
               held <= 1'b0;
            end else begin
               meta <= raw[i];
               held <= meta;
            end
         end

         assign lines[i] = held;

         // R2: a synchronized rise reflects the raw level two edges earlier
         a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(held) |-> $past(raw[i], 2));
      end
   endgenerate

endmodule

// File: rtl/ripint_slope.sv
module ripint_slope
   import ripint_pkg::*;
#(
   parameter int ACC_W   = 16,
   parameter int STEP    = 1,
   parameter int N_LINES = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tri_mode,
   input  logic [N_LINES-1:0]      lines,
   output logic signed [ACC_W-1:0] acc
);

   localparam int SW = ACC_W + 3;
   localparam logic signed [SW-1:0] INC_EARLY  = SW'(W_EARLY * STEP);
   localparam logic signed [SW-1:0] DEC_PAIR   = SW'(W_MID_PAIR * STEP);
   localparam logic signed [SW-1:0] DEC_TRIPLE = SW'(W_MID_TRIPLE * STEP);
   localparam logic signed [SW-1:0] INC_LATE   = SW'(W_LATE * STEP);
   localparam logic signed [SW-1:0] HI_S = {{(SW-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
   localparam logic signed [SW-1:0] LO_S = {{(SW-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] ACC_HI = HI_S[ACC_W-1:0];
   localparam logic signed [ACC_W-1:0] ACC_LO = LO_S[ACC_W-1:0];
   localparam logic signed [SW-1:0] MAX_MOVE = SW'(2 * STEP);

   generate
      if (ACC_W < 4) begin : g_bad_width
         $error("ripint_slope: ACC_W must be at least 4");
      end
      if (STEP < 1 || 4 * STEP >= (1 << (ACC_W - 1))) begin : g_bad_step
         $error("ripint_slope: STEP out of range for ACC_W");
      end
   endgenerate

   weight_mode_e mode;
   assign mode = weight_mode_e'(tri_mode);

   logic late_on;
   generate
      if (N_LINES == 3) begin : g_triple
         assign late_on = (mode == MODE_TRIPLE) && lines[2];
      end else begin : g_pair
         assign late_on = 1'b0;
      end
   endgenerate

   logic signed [SW-1:0]    delta;
   logic signed [SW-1:0]    sum;
   logic signed [ACC_W-1:0] acc_nxt;

   always_comb begin
      delta = '0;
      if (lines[0]) delta = delta + INC_EARLY;
      if (lines[1]) delta = delta - ((mode == MODE_TRIPLE) ? DEC_TRIPLE : DEC_PAIR);
      if (late_on)  delta = delta + INC_LATE;
      sum = {{3{acc[ACC_W-1]}}, acc} + delta;
      if (sum > HI_S)      acc_nxt = ACC_HI;
      else if (sum < LO_S) acc_nxt = ACC_LO;
      else                 acc_nxt = sum[ACC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else        acc <= acc_nxt;
   end

   // R3: no active line leaves the accumulator untouched
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(|lines) |=> $stable(acc));

   // R4: one cycle never moves the accumulator by more than two steps
   a_r4_bounded_move: assert property (@(posedge clk) disable iff (!rst_n)
      (|lines) |=> ((SW'(acc) - SW'($past(acc)) <= MAX_MOVE) &&
                    (SW'($past(acc)) - SW'(acc) <= MAX_MOVE)));

   // R6: at the upper limit without a falling line the value stays there
   a_r6_top_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_HI && !lines[1]) |=> (acc == ACC_HI));

   // R6: at the lower limit without a rising line the value stays there
   a_r6_bottom_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_LO && !lines[0] && (N_LINES < 3 || !tri_mode || !lines[N_LINES-1]))
      |=> (acc == ACC_LO));

   generate
      if (N_LINES == 3) begin : g_late_check
         // R5: a lone late line in two-line mode is ignored
         a_r5_late_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (!tri_mode && lines == 3'b100) |=> $stable(acc));
      end
   endgenerate

endmodule

// File: rtl/ripint_monitor.sv
module ripint_monitor #(
   parameter int ACC_W   = 16,
   parameter int QUIET_W = 8,
   parameter int AREA_W  = 32,
   parameter int N_LINES = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_LINES-1:0]       lines,
   input  logic [QUIET_W-1:0]       quiet_len,
   input  logic signed [ACC_W-1:0]  acc,
   output logic [ACC_W-1:0]         peak,
   output logic signed [AREA_W-1:0] area
);

   localparam int DW = ACC_W + 1;
   localparam int XW = AREA_W + 1;
   localparam logic signed [XW-1:0] AHI_X = {2'b00, {(AREA_W-1){1'b1}}};
   localparam logic signed [XW-1:0] ALO_X = {2'b11, {(AREA_W-1){1'b0}}};
   localparam logic signed [AREA_W-1:0] AREA_HI = AHI_X[AREA_W-1:0];
   localparam logic signed [AREA_W-1:0] AREA_LO = ALO_X[AREA_W-1:0];

   generate
      if (AREA_W < ACC_W + 4) begin : g_bad_area
         $error("ripint_monitor: AREA_W must exceed ACC_W by at least 4");
      end
      if (QUIET_W < 1) begin : g_bad_quiet
         $error("ripint_monitor: QUIET_W must be at least 1");
      end
   endgenerate

   logic signed [ACC_W-1:0] base;
   logic [QUIET_W-1:0]      quiet_cnt;
   logic                    any_act;
   logic                    settled;
   logic signed [DW-1:0]    dev;
   logic [ACC_W-1:0]        absdev;
   logic signed [XW-1:0]    area_sum;
   logic signed [AREA_W-1:0] area_nxt;

   assign any_act = |lines;
   assign settled = !any_act && (quiet_cnt >= quiet_len);
   assign dev     = {acc[ACC_W-1], acc} - {base[ACC_W-1], base};
   assign absdev  = ACC_W'(dev[DW-1] ? -dev : dev);

   always_comb begin
      area_sum = {area[AREA_W-1], area} + XW'(dev);
      if (area_sum > AHI_X)      area_nxt = AREA_HI;
      else if (area_sum < ALO_X) area_nxt = AREA_LO;
      else                       area_nxt = area_sum[AREA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_cnt <= '0;
      end else if (any_act) begin
         quiet_cnt <= '0;
      end else if (quiet_cnt < quiet_len) begin
         quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
         peak <= '0;
         area <= '0;
      end else if (settled) begin
         base <= acc;
         peak <= '0;
         area <= '0;
      end else begin
         if (absdev > peak) peak <= absdev;
         area <= area_nxt;
      end
   end

   // R7: the quiet state clears both burst results
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      settled |=> (peak == '0 && area == '0));

   // R8: peak never shrinks inside a burst
   a_r8_peak_grows: assert property (@(posedge clk) disable iff (!rst_n)
      !settled |=> (peak >= $past(peak)));

   // R8: peak always covers the excursion just seen
   a_r8_peak_covers: assert property (@(posedge clk) disable iff (!rst_n)
      !settled |=> (peak >= $past(absdev)));

   // R9: a zero excursion leaves the area unchanged
   a_r9_area_still: assert property (@(posedge clk) disable iff (!rst_n)
      (!settled && dev == '0) |=> $stable(area));

endmodule

// File: rtl/ripple_integrator.sv
module ripple_integrator #(
   parameter int ACC_W   = 16,
   parameter int STEP    = 1,
   parameter int QUIET_W = 8,
   parameter int AREA_W  = 32,
   parameter int N_LINES = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tri_mode,
   input  logic [QUIET_W-1:0]       quiet_len,
   input  logic [N_LINES-1:0]       pulse_in,
   output logic signed [ACC_W-1:0]  acc,
   output logic [ACC_W-1:0]         peak,
   output logic signed [AREA_W-1:0] area
);

   logic [N_LINES-1:0] lines;

   ripint_sync #(
      .N_LINES (N_LINES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (pulse_in),
      .lines (lines)
   );

   ripint_slope #(
      .ACC_W   (ACC_W),
      .STEP    (STEP),
      .N_LINES (N_LINES)
   ) u_slope (
      .clk      (clk),
      .rst_n    (rst_n),
      .tri_mode (tri_mode),
      .lines    (lines),
      .acc      (acc)
   );

   ripint_monitor #(
      .ACC_W   (ACC_W),
      .QUIET_W (QUIET_W),
      .AREA_W  (AREA_W),
      .N_LINES (N_LINES)
   ) u_monitor (
      .clk       (clk),
      .rst_n     (rst_n),
      .lines     (lines),
      .quiet_len (quiet_len),
      .acc       (acc),
      .peak      (peak),
      .area      (area)
   );

endmodule

// File: tb/ripple_integrator_test.sv
`timescale 1ns/1ps
module ripple_integrator_test;

   localparam int ACC_W   = 8;
   localparam int STEP    = 3;
   localparam int QUIET_W = 4;
   localparam int AREA_W  = 20;
   localparam int N_LINES = 3;
   localparam int ACC_MAX  = (1 << (ACC_W - 1)) - 1;
   localparam int ACC_MIN  = -(1 << (ACC_W - 1));
   localparam int AREA_MAX = (1 << (AREA_W - 1)) - 1;
   localparam int AREA_MIN = -(1 << (AREA_W - 1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tri_mode = 1'b0;
   logic [QUIET_W-1:0] quiet_len = 4'd4;
   logic [N_LINES-1:0] pulse_in = '0;
   logic signed [ACC_W-1:0]  acc;
   logic [ACC_W-1:0]         peak;
   logic signed [AREA_W-1:0] area;

   always #2.5 clk = ~clk;

   ripple_integrator #(
      .ACC_W (ACC_W), .STEP (STEP), .QUIET_W (QUIET_W),
      .AREA_W (AREA_W), .N_LINES (N_LINES)
   ) uut (
      .clk (clk), .rst_n (rst_n), .tri_mode (tri_mode), .quiet_len (quiet_len),
      .pulse_in (pulse_in), .acc (acc), .peak (peak), .area (area)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Reference state, derived from the requirements
   logic [2:0] m_s1 = '0;
   logic [2:0] m_s2 = '0;
   int m_acc = 0, m_cnt = 0, m_base = 0, m_peak = 0, m_area = 0;

   function automatic int f_clamp(int v, int lo, int hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   function automatic int f_delta(logic [2:0] l, logic md);
      int d = 0;
      if (l[0]) d += STEP;                       // R3
      if (l[1]) d -= (md ? 2 * STEP : STEP);     // R4
      if (md && l[2]) d += STEP;                 // R5
      return d;
   endfunction

   task automatic model_step();
      int dev = m_acc - m_base;
      int adev = (dev < 0) ? -dev : dev;
      bit act = |m_s2;
      bit sett = !act && (m_cnt >= int'(quiet_len));
      int n_acc = f_clamp(m_acc + f_delta(m_s2, tri_mode), ACC_MIN, ACC_MAX);
      int n_cnt = act ? 0 : ((m_cnt < int'(quiet_len)) ? m_cnt + 1 : m_cnt);
      if (sett) begin
         m_base = m_acc;
         m_peak = 0;
         m_area = 0;
      end else begin
         if (adev > m_peak) m_peak = adev;
         m_area = f_clamp(m_area + dev, AREA_MIN, AREA_MAX);
      end
      m_cnt = n_cnt;
      m_acc = n_acc;
      m_s2 = m_s1;
      m_s1 = pulse_in;
   endtask

   task automatic chk(string tag, int got, int exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic cycle();
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk("R4 acc vs model", int'(acc), m_acc);
      chk("R8 peak vs model", int'(peak), m_peak);
      chk("R9 area vs model", int'(area), m_area);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic hold(logic [2:0] p, int n);
      pulse_in = p;
      run(n);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd8675));
      repeat (3) @(negedge clk);
      chk("R1 acc in reset", int'(acc), 0);
      chk("R1 peak in reset", int'(peak), 0);
      chk("R1 area in reset", int'(area), 0);
      rst_n = 1'b1;

      // R2: latency of the two synchronizer stages
      tri_mode = 1'b0;
      pulse_in = 3'b001;
      cycle(); chk("R2 edge1", int'(acc), 0);
      cycle(); chk("R2 edge2", int'(acc), 0);
      cycle(); chk("R2 edge3", int'(acc), STEP);
      run(3);  chk("R3 early slope", int'(acc), 4 * STEP);
      hold(3'b000, 12);

      // R4: middle line in two-line mode
      hold(3'b010, 4);
      hold(3'b000, 3);
      chk("R4 pair fall", int'(acc), 6 * STEP - 4 * STEP);
      run(10);

      // R8/R9: two-line locked burst gives a positive area
      hold(3'b001, 6);
      hold(3'b010, 6);
      hold(3'b000, 3);
      chk("R8 pair peak", int'(peak), 6 * STEP);
      chk("R9 pair area", int'(area), 36 * STEP);
      chk("R9 pair net", int'(acc), 2 * STEP);
      run(10);
      chk("R7 peak cleared", int'(peak), 0);
      chk("R7 area cleared", int'(area), 0);

      // R9: three-line burst with doubled middle is zero-area
      tri_mode = 1'b1;
      hold(3'b001, 6);
      hold(3'b010, 6);
      hold(3'b100, 6);
      hold(3'b000, 3);
      chk("R8 triple peak", int'(peak), 6 * STEP);
      chk("R9 triple area", int'(area), 0);
      chk("R9 triple net", int'(acc), 2 * STEP);
      run(10);

      // R5: late line ignored in two-line mode, counted in three-line mode
      tri_mode = 1'b0;
      hold(3'b100, 5);
      hold(3'b000, 3);
      chk("R5 ignored acc", int'(acc), 2 * STEP);
      chk("R5 ignored peak", int'(peak), 0);
      chk("R5 ignored area", int'(area), 0);
      tri_mode = 1'b1;
      hold(3'b100, 2);
      hold(3'b000, 3);
      chk("R5 late counted", int'(acc), 4 * STEP);
      run(10);

      // R6: saturation at both limits
      tri_mode = 1'b0;
      hold(3'b001, 60);
      chk("R6 upper limit", int'(acc), ACC_MAX);
      hold(3'b010, 100);
      chk("R6 lower limit", int'(acc), ACC_MIN);
      hold(3'b000, 12);

      // R7: a longer quiet window keeps the results longer
      quiet_len = 4'd9;
      hold(3'b001, 2);
      hold(3'b000, 3);
      chk("R8 small peak", int'(peak), 2 * STEP);
      run(6);
      chk("R7 peak kept", int'(peak), 2 * STEP);
      run(6);
      chk("R7 peak cleared late", int'(peak), 0);

      // Constrained random bursts checked against the model
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(5) == 0) pulse_in = 3'($urandom_range(7));
         if ($urandom_range(3) == 0 && i % 40 > 25) pulse_in = '0;
         if ($urandom_range(199) == 0) tri_mode = ~tri_mode;
         if ($urandom_range(149) == 0) quiet_len = 4'($urandom_range(7));
         cycle();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule